// File: doc/BRIEF.md
# Interrupt Acceptance Sequencer

This block times how a small processor core takes an interrupt and sets its new interrupt priority level. A request strobe arrives with a source class and, for maskable sources, a priority level. The sequencer then waits for the instruction in flight to retire. Next it runs the interrupt sequence for a fixed number of cycles. That number depends on three things: the data bus width, the parity of the stack pointer and the vector address, and the source class. When the sequence ends, the block raises a one-cycle done pulse. In that same cycle it applies the class-specific priority-level update and publishes the measured response time.

The response time is the total number of cycles from the request cycle to the point where the handler's first instruction could start. It is the instruction-retire wait plus the sequence length. The core's pipeline uses the done pulse to begin fetching the handler. The updated level is the mask that later requests are compared against.

The controller has three states:
- `ST_IDLE` accepts a request with a legal class. It moves to `ST_WAIT_RETIRE`, or directly to `ST_SEQUENCE` if the instruction retires in the request cycle.
- `ST_WAIT_RETIRE` moves to `ST_SEQUENCE` in the cycle `insn_done` is high.
- `ST_SEQUENCE` counts the sequence cycles and returns to `ST_IDLE` after its last cycle. That return is the transition that produces the done pulse.

Top module: `irq_accept_seq`

## Requirements
- R1: After reset, `busy` and `seq_done` are 0, `ipl` is 0 and `resp_cycles` is 0.
- R2: A request in a cycle with `busy` low and a class code of 0 to 5 makes `busy` high from the next cycle. `busy` stays high until the cycle in which `seq_done` is high, and is low in that cycle.
- R3: With `bus_narrow` = 0, the sequence lasts 18 cycles when `sp_odd` and `vec_odd` are both 0, 19 cycles when exactly one of them is 1, and 20 cycles when both are 1.
- R4: With `bus_narrow` = 1, the sequence lasts 20 cycles whatever `sp_odd` and `vec_odd` are.
- R5: The sequence gains 2 cycles for class 4 (debug) and 1 cycle for class 3 (address match) and class 5 (single step). Classes 0, 1 and 2 add nothing.
- R6: `seq_done` is high in cycle W+L, counting the request cycle as cycle 0, and `resp_cycles` then equals W+L. W is the number of cycles from the request cycle through the first cycle with `insn_done` high, both included, so `insn_done` in the request cycle gives W = 1. L is the sequence length. `insn_done` while idle has no effect.
- R7: `seq_done` is a single-cycle pulse. `ipl` and `resp_cycles` change only in a cycle where `seq_done` is high, and they hold their values until the next such cycle.
- R8: For class 0 (maskable), `ipl` becomes the `req_level` captured with the request.
- R9: For class 1 (watchdog, non-maskable, oscillator fault, low voltage), `ipl` becomes 7.
- R10: For classes 2 to 5 (software, address match, debug, single step), `ipl` keeps its value.
- R11: While `busy` is high, requests are ignored. They change neither the sequence length, nor the resulting `ipl`, nor the response count, and they do not start a further sequence.
- R12: A request with class code 6 or 7 is ignored. `busy` stays low and `ipl` and `resp_cycles` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, sampled while idle |
| req_class | input | 3 | Source class code (0 to 5 legal) |
| req_level | input | IPL_W | Priority level of a maskable request |
| insn_done | input | 1 | The instruction in flight retires this cycle |
| sp_odd | input | 1 | Stack-pointer least significant bit at request time |
| vec_odd | input | 1 | Vector-address least significant bit at request time |
| bus_narrow | input | 1 | 1 selects the 8-bit bus, 0 the 16-bit bus |
| busy | output | 1 | Sequencer is in a request |
| seq_done | output | 1 | One-cycle pulse when the sequence has finished |
| ipl | output | IPL_W | Current interrupt priority level |
| resp_cycles | output | CNT_W | Response time of the last completed request |

## Verification
Every cycle, the assertions check the following:
- the busy/done handshake;
- that `seq_done` lasts a single cycle;
- that `ipl` and `resp_cycles` move only at a done pulse;
- the per-class priority-level rule;
- that the captured request is frozen while busy;
- that illegal classes are refused.

Only the bench's scenarios can show the exact sequence lengths for each combination of bus width, parity and class. They also show that the response count adds the retire wait to the sequence correctly, including a retire in the request cycle and the 30-cycle worst-case wait, and that stray strobes during a sequence leave its results untouched.

// File: rtl/irq_accept_pkg.sv
package irq_accept_pkg;

    typedef enum logic [2:0] {
        SRC_MASKABLE   = 3'd0,
        SRC_FORCED     = 3'd1,
        SRC_SOFT       = 3'd2,
        SRC_ADDR_MATCH = 3'd3,
        SRC_DEBUG      = 3'd4,
        SRC_STEP       = 3'd5
    } src_class_e;

    typedef enum logic [1:0] {
        ST_IDLE        = 2'd0,
        ST_WAIT_RETIRE = 2'd1,
        ST_SEQUENCE    = 2'd2
    } seq_state_e;

    localparam logic [2:0] LAST_LEGAL_CLASS = 3'd5;

    function automatic logic class_is_legal(input logic [2:0] cls);
        return cls <= LAST_LEGAL_CLASS;
    endfunction

endpackage

// File: rtl/irq_seq_len.sv
// Interrupt-sequence length from bus width, alignment and source class.
module irq_seq_len
    import irq_accept_pkg::*;
#(
    parameter int LEN_W      = 5,
    parameter int BASE_CYC   = 18,
    parameter int NARROW_CYC = 20
) (
    input  logic             bus_narrow,
    input  logic             sp_odd,
    input  logic             vec_odd,
    input  logic [2:0]       src_class,
    output logic [LEN_W-1:0] seq_len
);
    logic [LEN_W-1:0] base_len;
    logic [LEN_W-1:0] extra_len;

    always_comb begin
        if (bus_narrow) begin
            base_len = LEN_W'(NARROW_CYC);
        end else begin
            base_len = LEN_W'(BASE_CYC) + LEN_W'(sp_odd) + LEN_W'(vec_odd);
        end
    end

    always_comb begin
        case (src_class)
            SRC_DEBUG:                 extra_len = LEN_W'(2);
            SRC_ADDR_MATCH, SRC_STEP:  extra_len = LEN_W'(1);
            default:                   extra_len = '0;
        endcase
    end

    assign seq_len = base_len + extra_len;

endmodule

// File: rtl/irq_ipl_next.sv
// Priority level applied when a sequence completes.
module irq_ipl_next
    import irq_accept_pkg::*;
#(
    parameter int IPL_W = 3
) (
    input  logic [2:0]       src_class,
    input  logic [IPL_W-1:0] req_level,
    input  logic [IPL_W-1:0] cur_ipl,
    output logic [IPL_W-1:0] next_ipl
);
    always_comb begin
        case (src_class)
            SRC_MASKABLE: next_ipl = req_level;
            SRC_FORCED:   next_ipl = '1;
            default:      next_ipl = cur_ipl;
        endcase
    end
endmodule

// File: rtl/irq_accept_seq.sv
module irq_accept_seq
    import irq_accept_pkg::*;
#(
    parameter int IPL_W      = 3,
    parameter int CNT_W      = 8,
    parameter int BASE_CYC   = 18,
    parameter int NARROW_CYC = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [2:0]       req_class,
    input  logic [IPL_W-1:0] req_level,
    input  logic             insn_done,
    input  logic             sp_odd,
    input  logic             vec_odd,
    input  logic             bus_narrow,
    output logic             busy,
    output logic             seq_done,
    output logic [IPL_W-1:0] ipl,
    output logic [CNT_W-1:0] resp_cycles
);
    localparam int LEN_W = $clog2(NARROW_CYC + 3);

    seq_state_e       state_q, state_d;
    logic [2:0]       cls_q;
    logic [IPL_W-1:0] lvl_q;
    logic [IPL_W-1:0] ipl_q;
    logic [IPL_W-1:0] ipl_nxt;
    logic [LEN_W-1:0] len_d, len_q;
    logic [LEN_W-1:0] step_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] resp_q;
    logic             done_q;
    logic             accept;
    logic             last_step;

    irq_seq_len #(
        .LEN_W     (LEN_W),
        .BASE_CYC  (BASE_CYC),
        .NARROW_CYC(NARROW_CYC)
    ) len_i (
        .bus_narrow(bus_narrow),
        .sp_odd    (sp_odd),
        .vec_odd   (vec_odd),
        .src_class (req_class),
        .seq_len   (len_d)
    );

    irq_ipl_next #(.IPL_W(IPL_W)) ipl_i (
        .src_class(cls_q),
        .req_level(lvl_q),
        .cur_ipl  (ipl_q),
        .next_ipl (ipl_nxt)
    );

    assign accept    = (state_q == ST_IDLE) && req_valid && class_is_legal(req_class);
    assign last_step = (state_q == ST_SEQUENCE) && (step_q == len_q - LEN_W'(1));

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    state_d = insn_done ? ST_SEQUENCE : ST_WAIT_RETIRE;
                end
            end
            ST_WAIT_RETIRE: begin
                if (insn_done) begin
                    state_d = ST_SEQUENCE;
                end
            end
            ST_SEQUENCE: begin
                if (last_step) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Captured request, counters and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cls_q  <= '0;
            lvl_q  <= '0;
            len_q  <= '0;
            step_q <= '0;
            cnt_q  <= '0;
            resp_q <= '0;
            ipl_q  <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= last_step;
            if (accept) begin
                cls_q  <= req_class;
                lvl_q  <= req_level;
                len_q  <= len_d;
                step_q <= '0;
                cnt_q  <= CNT_W'(1);
            end else if (state_q != ST_IDLE) begin
                cnt_q <= cnt_q + CNT_W'(1);
            end
            if (state_q == ST_SEQUENCE) begin
                step_q <= step_q + LEN_W'(1);
            end
            if (last_step) begin
                ipl_q  <= ipl_nxt;
                resp_q <= cnt_q + CNT_W'(1);
            end
        end
    end

    assign busy        = (state_q != ST_IDLE);
    assign seq_done    = done_q;
    assign ipl         = ipl_q;
    assign resp_cycles = resp_q;

endmodule

// File: rtl/irq_accept_seq_chk.sv
module irq_accept_seq_chk
    import irq_accept_pkg::*;
#(
    parameter int IPL_W    = 3,
    parameter int CNT_W    = 8,
    parameter int BASE_CYC = 18
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic [2:0]       req_class,
    input logic             busy,
    input logic             seq_done,
    input logic [IPL_W-1:0] ipl,
    input logic [CNT_W-1:0] resp_cycles,
    input logic [2:0]       cls_q,
    input logic [IPL_W-1:0] lvl_q
);
    a_r2_accept_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && req_valid && req_class <= 3'd5) |=> busy);

    a_r2_busy_ends_at_done: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> seq_done);

    a_r2_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
        seq_done |-> !busy);

    a_r6_min_response: assert property (@(posedge clk) disable iff (!rst_n)
        seq_done |-> (resp_cycles >= CNT_W'(BASE_CYC + 1)));

    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        seq_done |=> !seq_done);

    a_r7_ipl_moves_on_done: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ipl) |-> seq_done);

    a_r7_resp_moves_on_done: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(resp_cycles) |-> seq_done);

    a_r8_maskable_level: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_done && cls_q == SRC_MASKABLE) |-> ipl == lvl_q);

    a_r9_forced_level: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_done && cls_q == SRC_FORCED) |-> ipl == '1);

    a_r10_level_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_done && cls_q >= SRC_SOFT) |-> ipl == $past(ipl));

    a_r11_busy_req_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(cls_q) && $stable(lvl_q)));

    a_r12_bad_class_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && req_valid && req_class > 3'd5) |=> !busy);

endmodule

bind irq_accept_seq irq_accept_seq_chk #(
    .IPL_W   (IPL_W),
    .CNT_W   (CNT_W),
    .BASE_CYC(BASE_CYC)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_class  (req_class),
    .busy       (busy),
    .seq_done   (seq_done),
    .ipl        (ipl),
    .resp_cycles(resp_cycles),
    .cls_q      (cls_q),
    .lvl_q      (lvl_q)
);

// File: tb/irq_accept_seq_tb.sv
module irq_accept_seq_tb_top;

    typedef struct packed {
        logic [2:0] cls;
        logic [2:0] lvl;
        logic       sp;
        logic       vec;
        logic       nar;
        logic [6:0] wait_c;
        logic [7:0] exp_resp;
    } vec_t;

    // exp_resp = wait + length (R3/R4/R5/R6)
    localparam int NVEC = 12;
    localparam vec_t VECS [NVEC] = '{
        '{3'd0, 3'd5, 1'b0, 1'b0, 1'b0, 7'd1,  8'd19},
        '{3'd0, 3'd2, 1'b1, 1'b0, 1'b0, 7'd4,  8'd23},
        '{3'd1, 3'd0, 1'b0, 1'b1, 1'b0, 7'd30, 8'd49},
        '{3'd2, 3'd6, 1'b1, 1'b1, 1'b0, 7'd2,  8'd22},
        '{3'd0, 3'd1, 1'b1, 1'b1, 1'b1, 7'd5,  8'd25},
        '{3'd4, 3'd0, 1'b0, 1'b0, 1'b0, 7'd3,  8'd23},
        '{3'd4, 3'd0, 1'b1, 1'b1, 1'b1, 7'd1,  8'd23},
        '{3'd3, 3'd0, 1'b1, 1'b0, 1'b0, 7'd2,  8'd22},
        '{3'd5, 3'd3, 1'b0, 1'b0, 1'b1, 7'd7,  8'd28},
        '{3'd3, 3'd0, 1'b0, 1'b0, 1'b1, 7'd1,  8'd22},
        '{3'd1, 3'd3, 1'b1, 1'b1, 1'b1, 7'd2,  8'd22},
        '{3'd0, 3'd0, 1'b0, 1'b1, 1'b1, 7'd10, 8'd30}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [2:0] req_class = '0;
    logic [2:0] req_level = '0;
    logic       insn_done = 1'b0;
    logic       sp_odd = 1'b0;
    logic       vec_odd = 1'b0;
    logic       bus_narrow = 1'b0;
    logic       busy, seq_done;
    logic [2:0] ipl;
    logic [7:0] resp_cycles;

    int n_checks = 0;
    int n_fail = 0;
    logic [2:0] model_ipl = '0;

    always #4 clk = ~clk;

    irq_accept_seq dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_class(req_class),
        .req_level(req_level), .insn_done(insn_done), .sp_odd(sp_odd),
        .vec_odd(vec_odd), .bus_narrow(bus_narrow), .busy(busy),
        .seq_done(seq_done), .ipl(ipl), .resp_cycles(resp_cycles)
    );

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Runs one request; noise drives stray requests while busy (R11).
    task automatic run_req(input logic [2:0] cls, input logic [2:0] lvl, input logic sp,
                           input logic vec, input logic nar, input int w,
                           input int exp_resp, input logic noise, input string tag);
        int n;
        @(negedge clk);
        req_valid = 1'b1; req_class = cls; req_level = lvl;
        sp_odd = sp; vec_odd = vec; bus_narrow = nar;
        insn_done = (w == 1);
        for (int k = 1; k < w; k++) begin
            @(negedge clk);
            req_valid = 1'b0;
            sp_odd = ~sp; vec_odd = ~vec; bus_narrow = ~nar;
            insn_done = (k == w - 1);
        end
        @(negedge clk);
        req_valid = 1'b0; insn_done = 1'b0;
        n = w;
        while (!seq_done && n < 200) begin
            if (noise && n < w + 10) begin
                req_valid = 1'b1; req_class = 3'd4; req_level = 3'd6;
                bus_narrow = 1'b1; sp_odd = 1'b1; vec_odd = 1'b1;
            end else begin
                req_valid = 1'b0;
            end
            @(negedge clk);
            n++;
        end
        req_valid = 1'b0;
        if (cls == 3'd0) model_ipl = lvl;
        else if (cls == 3'd1) model_ipl = 3'd7;
        chk(n == exp_resp, {tag, " R6 done cycle"}, n, exp_resp);
        chk(resp_cycles == 8'(exp_resp), {tag, " R6 resp_cycles"}, resp_cycles, exp_resp);
        chk(ipl == model_ipl, {tag, " R8/R9/R10 ipl"}, ipl, model_ipl);
        chk(!busy, {tag, " R2 busy low at done"}, busy, 0);
        @(negedge clk);
        chk(!seq_done, {tag, " R7 single pulse"}, seq_done, 0);
    endtask

    initial begin
        logic [2:0] ipl_before;
        logic [7:0] resp_before;
        repeat (3) @(negedge clk);
        // R1: reset values
        chk(!busy && !seq_done, "R1 busy/done", {busy, seq_done}, 0);
        chk(ipl == 3'd0, "R1 ipl", ipl, 0);
        chk(resp_cycles == 8'd0, "R1 resp", resp_cycles, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Table walk: R3, R4, R5, R6, R8, R9, R10
        for (int i = 0; i < NVEC; i++) begin
            run_req(VECS[i].cls, VECS[i].lvl, VECS[i].sp, VECS[i].vec, VECS[i].nar,
                    int'(VECS[i].wait_c), int'(VECS[i].exp_resp), 1'b0,
                    $sformatf("vec%0d R3/R4/R5", i));
        end

        // R11: stray requests while busy change nothing
        run_req(3'd0, 3'd3, 1'b0, 1'b0, 1'b0, 1, 19, 1'b1, "R11 noise");
        repeat (3) @(negedge clk);
        chk(!busy, "R11 no extra sequence", busy, 0);

        // R12: illegal class codes ignored; R7: outputs hold
        ipl_before = ipl; resp_before = resp_cycles;
        for (int c = 6; c < 8; c++) begin
            @(negedge clk);
            req_valid = 1'b1; req_class = 3'(c); req_level = 3'd1; insn_done = 1'b1;
            @(negedge clk);
            req_valid = 1'b0; insn_done = 1'b0;
            chk(!busy, "R12 illegal class busy", busy, 0);
        end
        repeat (25) @(negedge clk);
        chk(!seq_done && ipl == ipl_before, "R12 ipl kept", ipl, ipl_before);
        chk(resp_cycles == resp_before, "R7 resp held", resp_cycles, resp_before);

        // R6: insn_done while idle has no effect
        @(negedge clk);
        insn_done = 1'b1;
        @(negedge clk);
        insn_done = 1'b0;
        run_req(3'd1, 3'd0, 1'b0, 1'b0, 1'b0, 3, 21, 1'b0, "R6 idle retire");

        // R2: busy from the cycle after acceptance
        @(negedge clk);
        req_valid = 1'b1; req_class = 3'd2; sp_odd = 1'b0; vec_odd = 1'b0;
        bus_narrow = 1'b0; insn_done = 1'b0;
        @(negedge clk);
        req_valid = 1'b0;
        chk(busy, "R2 busy after accept", busy, 1);
        insn_done = 1'b1;
        @(negedge clk);
        insn_done = 1'b0;
        repeat (40) @(negedge clk);
        chk(!busy, "R2 busy released", busy, 0);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule